// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor

This block is a small processor built around one accumulator. Every access to memory passes through two holding registers: an address register that drives the memory address and a data buffer register that receives read data and supplies write data. A control state machine runs each instruction as a fixed chain of single register transfers:

- Fetch brings the next instruction word into the instruction register and advances the program counter.
- Decode selects the execute chain from the opcode.
- Execute performs the chosen operation.

The instruction word is 8 bits. The top 3 bits are the opcode and the low 5 bits are the operand address. Every arithmetic or logic result goes back into the accumulator.

The processor connects to one single-port synchronous memory. The memory takes an address, a write enable and write data. It returns read data one clock after it is given an address. The instruction set covers:

- load, store, add, subtract, AND, OR and invert;
- an unconditional jump;
- a jump taken only when the accumulator is zero;
- a halt that parks the machine until reset.

Top module: `acc_cpu`

## Requirements
- R1: With `rst` high at a rising clock edge, the block clears the accumulator, program counter, instruction and address registers, drops `halted` and `mem_we`, and restarts fetching from address 0.
- R2: Instructions run from consecutive addresses starting at 0. For each instruction, the program counter is placed on `mem_addr`, the read word is captured and moved into the instruction register, and the program counter then advances by one.
- R3: Opcode 000 (load) reads memory at the 5-bit address field and places that word in the accumulator.
- R4: Opcode 001 (store) drives the address field on `mem_addr` and the accumulator on `mem_wdata`, and raises `mem_we` for exactly one cycle.
- R5: Opcode 010 (add) and opcode 011 (subtract) replace the accumulator with the accumulator plus, or minus, the addressed memory word, modulo 256.
- R6: Opcode 100 (AND) and opcode 101 (OR) with an address field other than 31 replace the accumulator with its bitwise AND, or OR, with the addressed memory word.
- R7: Opcode 101 with address field 31 inverts the accumulator bitwise and reads no memory, so `mem_addr` never shows 31 for it.
- R8: Opcode 110 (jump) sets the program counter to the address field, so the next fetch reads from there.
- R9: Opcode 111 with a nonzero address field jumps to that address only when the accumulator is zero. Otherwise execution continues at the next address.
- R10: Opcode 111 with address field 0 (halt) raises `halted`. While halted, the accumulator and program counter hold and `mem_we` stays low, until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 5 | Memory address, driven from the address register |
| mem_wdata | output | 8 | Memory write data, driven from the data buffer register |
| mem_we | output | 1 | Memory write enable, one cycle per store |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the address is presented |
| acc_q | output | 8 | Current accumulator value |
| halted | output | 1 | High while the machine is parked after a halt |

## Verification
The assertions assume that the memory follows the one-cycle read latency and returns a stable word for each address it is given. They also assume that reset is held for at least one rising edge before any program runs. The bench models the memory as a registered-output array, so read data always arrives exactly one cycle after the address. It loads each program only while reset is asserted, so the processor never fetches from a memory that is changing. Each program ends in a halt placed before address 31, so the only way 31 can appear on the address lines is an invert instruction wrongly reading memory.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int OPC_W = 3;

   typedef enum logic [OPC_W-1:0] {
      OP_LOAD  = 3'd0,
      OP_STORE = 3'd1,
      OP_ADD   = 3'd2,
      OP_SUB   = 3'd3,
      OP_AND   = 3'd4,
      OP_OR    = 3'd5,
      OP_JMP   = 3'd6,
      OP_SYS   = 3'd7
   } opcode_e;

   typedef enum logic [2:0] {
      ALU_PASS,
      ALU_ADD,
      ALU_SUB,
      ALU_AND,
      ALU_OR,
      ALU_INV
   } alu_op_e;

   typedef enum logic [3:0] {
      S_FMAR,
      S_FRD,
      S_FMBR,
      S_FIR,
      S_DEC,
      S_XMAR,
      S_XRD,
      S_XMBR,
      S_XWB,
      S_SMAR,
      S_SWR,
      S_BR,
      S_HALT
   } state_e;

   typedef struct packed {
      logic    mar_pc;
      logic    mar_ir;
      logic    mbr_mem;
      logic    mbr_acc;
      logic    ir_mbr;
      logic    pc_inc;
      logic    pc_load;
      logic    acc_load;
      alu_op_e alu_op;
   } ctl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int W           = 8,
   parameter bit SUB_VIA_ADD = 1'b1
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [W-1:0]   y
);

   logic [W-1:0] sum;
   logic [W-1:0] diff;

   assign sum = a + b;

   generate
      if (SUB_VIA_ADD) begin : g_sub_add
         // two's complement: a + ~b + 1 shares the adder structure
         assign diff = a + (~b) + W'(1);
      end else begin : g_sub_direct
         assign diff = a - b;
      end
   endgenerate

   always_comb begin
      unique case (op)
         ALU_ADD:  y = sum;
         ALU_SUB:  y = diff;
         ALU_AND:  y = a & b;
         ALU_OR:   y = a | b;
         ALU_INV:  y = ~a;
         default:  y = b;
      endcase
   end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
   import acc_cpu_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  opcode_e           ir_op,
   input  logic [ADDR_W-1:0] ir_addr,
   input  logic              acc_zero,
   output ctl_t              ctl,
   output logic              mem_we,
   output logic              halted
);

   localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

   state_e  st, nxt;
   alu_op_e exec_op;
   logic    addr_is_max;
   logic    addr_is_zero;

   assign addr_is_max  = (ir_addr == ADDR_MAX);
   assign addr_is_zero = (ir_addr == '0);

   always_comb begin
      unique case (ir_op)
         OP_ADD:  exec_op = ALU_ADD;
         OP_SUB:  exec_op = ALU_SUB;
         OP_AND:  exec_op = ALU_AND;
         OP_OR:   exec_op = addr_is_max ? ALU_INV : ALU_OR;
         default: exec_op = ALU_PASS;
      endcase
   end

   always_comb begin
      nxt        = st;
      ctl        = '0;
      ctl.alu_op = ALU_PASS;
      mem_we     = 1'b0;
      unique case (st)
         S_FMAR: begin
            ctl.mar_pc = 1'b1;
            nxt        = S_FRD;
         end
         S_FRD:  nxt = S_FMBR;
         S_FMBR: begin
            ctl.mbr_mem = 1'b1;
            nxt         = S_FIR;
         end
         S_FIR: begin
            ctl.ir_mbr = 1'b1;
            ctl.pc_inc = 1'b1;
            nxt        = S_DEC;
         end
         S_DEC: begin
            unique case (ir_op)
               OP_STORE: nxt = S_SMAR;
               OP_JMP:   nxt = S_BR;
               OP_SYS:   nxt = addr_is_zero ? S_HALT : S_BR;
               OP_OR:    nxt = addr_is_max ? S_XWB : S_XMAR;
               default:  nxt = S_XMAR;
            endcase
         end
         S_XMAR: begin
            ctl.mar_ir = 1'b1;
            nxt        = S_XRD;
         end
         S_XRD:  nxt = S_XMBR;
         S_XMBR: begin
            ctl.mbr_mem = 1'b1;
            nxt         = S_XWB;
         end
         S_XWB: begin
            ctl.acc_load = 1'b1;
            ctl.alu_op   = exec_op;
            nxt          = S_FMAR;
         end
         S_SMAR: begin
            ctl.mar_ir  = 1'b1;
            ctl.mbr_acc = 1'b1;
            nxt         = S_SWR;
         end
         S_SWR: begin
            mem_we = 1'b1;
            nxt    = S_FMAR;
         end
         S_BR: begin
            ctl.pc_load = (ir_op == OP_JMP) || acc_zero;
            nxt         = S_FMAR;
         end
         default: nxt = S_HALT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st <= S_FMAR;
      else     st <= nxt;
   end

   assign halted = (st == S_HALT);

   assert_we_single_R4: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> !mem_we);

   assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
      halted |=> halted);

   assert_halt_no_write_R10: assert property (@(posedge clk) disable iff (rst)
      halted |-> !mem_we);

   assert_ctl_onehot_mar_R2: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ctl.mar_pc, ctl.mar_ir}));

endmodule

// File: rtl/acc_cpu_path.sv
module acc_cpu_path
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = DATA_W - OPC_W
) (
   input  logic              clk,
   input  logic              rst,
   input  ctl_t              ctl,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] alu_y,
   output logic [ADDR_W-1:0] mar,
   output logic [DATA_W-1:0] mbr,
   output logic [DATA_W-1:0] acc,
   output logic [ADDR_W-1:0] pc,
   output opcode_e           ir_op,
   output logic [ADDR_W-1:0] ir_addr
);

   logic [DATA_W-1:0] ir;

   assign ir_op   = opcode_e'(ir[DATA_W-1 -: OPC_W]);
   assign ir_addr = ir[ADDR_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         pc  <= '0;
         acc <= '0;
         ir  <= '0;
         mar <= '0;
         mbr <= '0;
      end else begin
         if (ctl.mar_pc)       mar <= pc;
         else if (ctl.mar_ir)  mar <= ir_addr;

         if (ctl.mbr_mem)      mbr <= mem_rdata;
         else if (ctl.mbr_acc) mbr <= acc;

         if (ctl.ir_mbr)       ir <= mbr;

         if (ctl.pc_load)      pc <= ir_addr;
         else if (ctl.pc_inc)  pc <= pc + ADDR_W'(1);

         if (ctl.acc_load)     acc <= alu_y;
      end
   end

   assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
      ctl.ir_mbr |=> (pc == ADDR_W'($past(pc) + ADDR_W'(1))));

   assert_ir_from_mbr_R2: assert property (@(posedge clk) disable iff (rst)
      ctl.ir_mbr |=> (ir == $past(mbr)));

   assert_acc_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !ctl.acc_load |=> $stable(acc));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit SUB_VIA_ADD = 1'b1,
   localparam int ADDR_W     = DATA_W - OPC_W
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] acc_q,
   output logic              halted
);

   initial begin
      assert_param_width: assert (DATA_W > OPC_W + 1)
         else $error("data width leaves no room for the address field");
   end

   ctl_t              ctl;
   opcode_e           ir_op;
   logic [ADDR_W-1:0] ir_addr;
   logic [ADDR_W-1:0] pc;
   logic [DATA_W-1:0] acc;
   logic [DATA_W-1:0] mbr;
   logic [DATA_W-1:0] alu_y;

   acc_cpu_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .ir_op    (ir_op),
      .ir_addr  (ir_addr),
      .acc_zero (acc == '0),
      .ctl      (ctl),
      .mem_we   (mem_we),
      .halted   (halted)
   );

   acc_cpu_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_path (
      .clk       (clk),
      .rst       (rst),
      .ctl       (ctl),
      .mem_rdata (mem_rdata),
      .alu_y     (alu_y),
      .mar       (mem_addr),
      .mbr       (mbr),
      .acc       (acc),
      .pc        (pc),
      .ir_op     (ir_op),
      .ir_addr   (ir_addr)
   );

   acc_cpu_alu #(.W(DATA_W), .SUB_VIA_ADD(SUB_VIA_ADD)) u_alu (
      .op (ctl.alu_op),
      .a  (acc),
      .b  (mbr),
      .y  (alu_y)
   );

   assign mem_wdata = mbr;
   assign acc_q     = acc;

   assert_store_data_R4: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> (mem_wdata == acc));

   assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (rst)
      halted |=> ($stable(acc) && $stable(pc)));

endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;

   localparam int CLK_PERIOD = 10;
   localparam int RUN_LIMIT  = 2000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [4:0] mem_addr;
   logic [7:0] mem_wdata;
   logic       mem_we;
   logic [7:0] mem_rdata;
   logic [7:0] acc_q;
   logic       halted;

   logic [7:0] mem [32];
   int         checks = 0;
   int         fails  = 0;
   int         we_cnt = 0;
   int         a31_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_cpu u_dut (
      .clk       (clk),
      .rst       (rst),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_rdata (mem_rdata),
      .acc_q     (acc_q),
      .halted    (halted)
   );

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
      if (!rst && mem_we) we_cnt <= we_cnt + 1;
      if (!rst && mem_addr == 5'd31) a31_cnt <= a31_cnt + 1;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 32; i++) mem[i] = 8'hE0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      we_cnt  = 0;
      a31_cnt = 0;
      rst = 1'b0;
   endtask

   task automatic run_to_halt(input string req);
      int n = 0;
      while (!halted && n < RUN_LIMIT) begin
         @(negedge clk);
         n++;
      end
      chk({req, " halt reached"}, int'(halted), 1);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      clear_mem();
      do_reset();
      chk("R1 acc", acc_q, 0);
      chk("R1 halted", halted, 0);
      chk("R1 mem_we", mem_we, 0);
      chk("R1 mem_addr", mem_addr, 0);
   endtask

   task automatic t_arith();
      rst = 1'b1;
      clear_mem();
      mem[0] = 8'h14; mem[1] = 8'h55; mem[2] = 8'h39;
      mem[3] = 8'h76; mem[4] = 8'h3A; mem[5] = 8'hE0;
      mem[20] = 8'hF0; mem[21] = 8'h25; mem[22] = 8'h20;
      do_reset();
      run_to_halt("R2");
      chk("R3 R5 add wrap stored", mem[25], 8'h15);
      chk("R5 sub wrap stored", mem[26], 8'hF5);
      chk("R3 R5 acc", acc_q, 8'hF5);
      chk("R4 write pulses", we_cnt, 2);
   endtask

   task automatic t_logic();
      rst = 1'b1;
      clear_mem();
      mem[0] = 8'h14; mem[1] = 8'h95; mem[2] = 8'hB6;
      mem[3] = 8'hBF; mem[4] = 8'h37; mem[5] = 8'hE0;
      mem[20] = 8'h3C; mem[21] = 8'h0F; mem[22] = 8'h50;
      mem[31] = 8'hFF;
      do_reset();
      run_to_halt("R6");
      chk("R6 R7 and/or/invert stored", mem[23], 8'hA3);
      chk("R7 no read of address 31", a31_cnt, 0);
      chk("R7 acc", acc_q, 8'hA3);
   endtask

   task automatic t_jump();
      rst = 1'b1;
      clear_mem();
      mem[0] = 8'h14; mem[1] = 8'hE4; mem[2] = 8'h38; mem[3] = 8'hE0;
      mem[4] = 8'h15; mem[5] = 8'hE8; mem[6] = 8'h39; mem[7] = 8'hCA;
      mem[8] = 8'h3A; mem[9] = 8'hE0; mem[10] = 8'h3B; mem[11] = 8'hE0;
      mem[20] = 8'h00; mem[21] = 8'h07;
      for (int i = 24; i < 28; i++) mem[i] = 8'h55;
      do_reset();
      run_to_halt("R8");
      chk("R9 taken when zero", mem[24], 8'h55);
      chk("R9 not taken when nonzero", mem[25], 8'h07);
      chk("R8 jump skips", mem[26], 8'h55);
      chk("R8 jump target runs", mem[27], 8'h07);
   endtask

   task automatic t_halt();
      rst = 1'b1;
      clear_mem();
      mem[0] = 8'h14; mem[1] = 8'hE0; mem[2] = 8'h35;
      mem[20] = 8'h6B; mem[21] = 8'h11;
      do_reset();
      run_to_halt("R10");
      repeat (25) @(negedge clk);
      chk("R10 halted holds", halted, 1);
      chk("R10 acc frozen", acc_q, 8'h6B);
      chk("R10 no writes", we_cnt, 0);
      chk("R10 memory untouched", mem[21], 8'h11);
      do_reset();
      chk("R10 R1 reset clears halted", halted, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_arith();
      t_logic();
      t_jump();
      t_halt();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule